// File: doc/BRIEF.md
# Instruction Slowdown Insertion Controller

This block sits beside the fetch stage of a five-stage in-order pipeline and lowers the pipeline's power without touching the clock. A power management unit supplies an integer slowdown factor n at run time. After each real fetch the controller holds fetch off for n−1 cycles and sends a locally generated bubble down the pipeline in each of them. The clock keeps its rated frequency, so the slowdown comes only from these inserted cycles.

In every bubble cycle the controller also drives a fixed set of low-power controls. Combinational units are power gated. State-holding registers are clock gated, so their contents survive. Both memories are put into a drowsy state. The controller itself stays powered at all times. Two free-running counters report how many real and bubble cycles have passed since reset, so the fetch-to-bubble ratio can be read at the ports.

Top module: `slowdown_injector`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, fetch_en_o is 1, bubble_o is 0, every bit of pg_o, cg_o and drowsy_o is 0, and both counters read 0.
- R2: With a factor n from 2 to 15, each real fetch cycle is followed by exactly n−1 bubble cycles and then the next real fetch. fetch_en_o is 1 exactly in the cycles where bubble_o is 0.
- R3: A factor of 0 or 1 inserts no bubbles, so fetch_en_o stays 1 in every cycle.
- R4: The factor is sampled only in a real fetch cycle. A change to factor_i during a bubble run does not change the length of that run.
- R5: In every bubble cycle all power-gate bits are 1. The bit positions are: pg_o[0] PC incrementer, [1] forwarding unit, [2] hazard unit, [3] ALU, [4] comparator, [5] three-input mux, [6] two-input mux, [7] branch target adder, [8] writeback forwarding path. In the same cycles all clock-gate bits are 1: cg_o[0] PC, [1] register file, [2] IF/ID, [3] ID/EX, [4] EX/MEM, [5] MEM/WB. Both drowsy bits are 1: drowsy_o[0] instruction memory, [1] data memory.
- R6: In every real fetch cycle all bits of pg_o, cg_o and drowsy_o are 0. Every gated unit is therefore awake when an instruction is fetched.
- R7: real_cnt_o and bubble_cnt_o count the fetch cycles and bubble cycles completed since reset. Each counter shows its increment in the cycle after the counted one and wraps modulo 2^CNT_W.
- R8: Asserting reset in the middle of a bubble run abandons the run at once and returns all outputs to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rated-frequency clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| factor_i | input | FACTOR_W | Slowdown factor n from the power manager (0 treated as 1) |
| fetch_en_o | output | 1 | High in cycles where the fetch stage may fetch a real instruction |
| bubble_o | output | 1 | High in cycles that carry an inserted bubble into the pipeline |
| pg_o | output | 9 | Power-gate enables for combinational units, 1 = gated |
| cg_o | output | 6 | Clock-gate enables for state registers, 1 = clock stopped |
| drowsy_o | output | 2 | Drowsy requests for instruction and data memory |
| real_cnt_o | output | CNT_W | Completed real fetch cycles since reset |
| bubble_cnt_o | output | CNT_W | Completed bubble cycles since reset |

## Verification
A corrupted run counter shows up at fetch_en_o in the very cycle it goes wrong: a run that is one bubble too short or too long moves the next fetch. Both status counters also drift from the arithmetic ratio in the following cycle. The low-power flop is separate from the run counter, so a fault in it appears as a gating bit that disagrees with bubble_o in the same cycle. Sweeping every factor, and changing the factor in every cycle, exposes any sampling outside a fetch cycle on the first run whose length differs.

// File: rtl/slowdown_injector.sv
module slowdown_injector #(
  parameter int FACTOR_W = 4,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FACTOR_W-1:0] factor_i,
  output logic                fetch_en_o,
  output logic                bubble_o,
  output logic [8:0]          pg_o,
  output logic [5:0]          cg_o,
  output logic [1:0]          drowsy_o,
  output logic [CNT_W-1:0]    real_cnt_o,
  output logic [CNT_W-1:0]    bubble_cnt_o
);

  localparam int PG_N = 9;
  localparam int CG_N = 6;
  localparam int DR_N = 2;

  logic [FACTOR_W-1:0] left_q, left_d, reload;
  logic                lp_q;

  assign reload   = (factor_i == '0) ? '0 : factor_i - 1'b1;
  assign bubble_o = (left_q != '0);
  assign fetch_en_o = ~bubble_o;
  assign left_d   = bubble_o ? left_q - 1'b1 : reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q       <= '0;
      lp_q         <= 1'b0;
      real_cnt_o   <= '0;
      bubble_cnt_o <= '0;
    end else begin
      left_q <= left_d;
      lp_q   <= (left_d != '0);
      if (bubble_o) bubble_cnt_o <= bubble_cnt_o + 1'b1;
      else          real_cnt_o   <= real_cnt_o + 1'b1;
    end
  end

  assign pg_o     = {PG_N{lp_q}};
  assign cg_o     = {CG_N{lp_q}};
  assign drowsy_o = {DR_N{lp_q}};

endmodule

// File: rtl/slowdown_injector_chk.sv
module slowdown_injector_chk #(
  parameter int FACTOR_W = 4,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [FACTOR_W-1:0] factor_i,
  input logic                fetch_en_o,
  input logic                bubble_o,
  input logic [8:0]          pg_o,
  input logic [5:0]          cg_o,
  input logic [1:0]          drowsy_o,
  input logic [CNT_W-1:0]    real_cnt_o,
  input logic [CNT_W-1:0]    bubble_cnt_o
);

  logic [FACTOR_W-1:0] want_q, run_q;
  logic                seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= '0;
      run_q  <= '0;
      seen_q <= 1'b0;
    end else if (fetch_en_o) begin
      want_q <= (factor_i == '0) ? '0 : factor_i - 1'b1;
      run_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en_o && seen_q) |-> (run_q == want_q));

  a_r3_no_insert: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en_o && factor_i <= 1) |=> fetch_en_o);

  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |-> ((&pg_o) && (&cg_o) && (&drowsy_o)));

  a_r6_awake: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en_o |-> (pg_o == '0 && cg_o == '0 && drowsy_o == '0));

  a_r7_real_count: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en_o |=> (real_cnt_o == $past(real_cnt_o) + 1'b1));

  a_r7_bubble_count: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |=> (bubble_cnt_o == $past(bubble_cnt_o) + 1'b1));

endmodule

bind slowdown_injector slowdown_injector_chk #(.FACTOR_W(FACTOR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .factor_i(factor_i), .fetch_en_o(fetch_en_o),
  .bubble_o(bubble_o), .pg_o(pg_o), .cg_o(cg_o), .drowsy_o(drowsy_o),
  .real_cnt_o(real_cnt_o), .bubble_cnt_o(bubble_cnt_o));

// File: tb/slowdown_injector_test.sv
module slowdown_injector_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  factor_i = 4'd1;
  logic        fetch_en_o, bubble_o;
  logic [8:0]  pg_o;
  logic [5:0]  cg_o;
  logic [1:0]  drowsy_o;
  logic [15:0] real_cnt_o, bubble_cnt_o;

  int nchecks = 0;
  int nfail = 0;
  int m_left = 0;
  int m_real = 0;
  int m_bub = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  slowdown_injector uut (
    .clk(clk), .rst_n(rst_n), .factor_i(factor_i), .fetch_en_o(fetch_en_o),
    .bubble_o(bubble_o), .pg_o(pg_o), .cg_o(cg_o), .drowsy_o(drowsy_o),
    .real_cnt_o(real_cnt_o), .bubble_cnt_o(bubble_cnt_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_reset_state(input string req);
    chk(fetch_en_o == 1'b1, {req, " fetch_en"}, fetch_en_o, 1);
    chk(bubble_o == 1'b0, {req, " bubble"}, bubble_o, 0);
    chk({pg_o, cg_o, drowsy_o} == '0, {req, " lp controls"}, {pg_o, cg_o, drowsy_o}, 0);
    chk(real_cnt_o == 16'd0 && bubble_cnt_o == 16'd0, {req, " counters"},
        {real_cnt_o, bubble_cnt_o}, 0);
  endtask

  task automatic step(input int f, input string tag);
    bit exp_b;
    exp_b = (m_left != 0);
    chk(fetch_en_o == !exp_b, {tag, " fetch_en"}, fetch_en_o, !exp_b);
    chk(bubble_o == exp_b, {tag, " bubble"}, bubble_o, exp_b);
    if (exp_b) begin
      chk(pg_o == 9'h1FF, "R5 pg_o", pg_o, 9'h1FF);
      chk(cg_o == 6'h3F, "R5 cg_o", cg_o, 6'h3F);
      chk(drowsy_o == 2'h3, "R5 drowsy_o", drowsy_o, 2'h3);
    end else begin
      chk({pg_o, cg_o, drowsy_o} == '0, "R6 awake", {pg_o, cg_o, drowsy_o}, 0);
    end
    chk(real_cnt_o == 16'(m_real), "R7 real count", real_cnt_o, m_real);
    chk(bubble_cnt_o == 16'(m_bub), "R7 bubble count", bubble_cnt_o, m_bub);
    factor_i = 4'(f);
    if (m_left == 0) begin
      m_real++;
      m_left = (f == 0) ? 0 : f - 1;
    end else begin
      m_bub++;
      m_left--;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nchecks++;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state("R1 in reset");
    rst_n = 1'b1;
    chk_reset_state("R1 after release");

    // R3: factors 0 and 1 never insert
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 6; i++) step(f, "R3");

    // R2: sweep every factor, three full periods each
    for (int f = 2; f < 16; f++)
      for (int i = 0; i < 3 * f + 1; i++) step(f, "R2");

    // R4: factor changes in every cycle; only fetch cycles may sample it
    for (int i = 0; i < 300; i++) step((i * 7 + 3) % 16, "R4");

    // R7: a clean ratio segment at n=5 from a boundary
    while (m_left != 0) step(5, "R7");
    for (int i = 0; i < 50; i++) step(5, "R7");
    chk(m_bub >= 0, "R7 model", m_bub, m_bub);

    // R8: reset in the middle of a bubble run
    while (m_left == 0) step(9, "R8");
    step(9, "R8");
    chk(bubble_o == 1'b1, "R8 inside run", bubble_o, 1);
    rst_n = 1'b0;
    #1;
    chk_reset_state("R8 abort");
    @(negedge clk);
    rst_n = 1'b1;
    m_left = 0;
    m_real = 0;
    m_bub = 0;
    chk_reset_state("R8 after release");
    for (int i = 0; i < 20; i++) step(3, "R8");

    finish_run();
  end

endmodule